// File: doc/BRIEF.md
# Video Memory DMA Sequencer

This block sequences direct memory transfers into the video memory of a display processor. Three transfer kinds are supported. A bus transfer copies 16-bit words from the external bus into video memory. A fill repeats one byte of a fill value across a range. A copy moves bytes from one place in video memory to another. Software programs a 24-bit source address as three bytes, a 16-bit length, an 8-bit auto-increment and a destination address. It then issues a command word whose start bit launches the transfer.

On every access slot that the transfer kind may use, the sequencer presents one write request for a single cycle. The request carries the address, the data, the target code, a byte-lane flag and, for bus transfers, the queue latency. After each step it advances the source, the destination and the length. It signals the final step with a one-cycle pulse.

The controller has five states. `ST_IDLE` is the rest state. `ST_FILL_ARM` is a fill that has been commanded and waits for its data word. `ST_BUS`, `ST_FILL` and `ST_COPY` are the three running states. The transitions are:
- start-bus, start-copy and arm-fill, all from `ST_IDLE` or `ST_FILL_ARM` on a command write;
- fill-data, from `ST_FILL_ARM` to `ST_FILL` on a data write;
- cancel, back to `ST_IDLE` on a command write without the start bit;
- finish, from any running state to `ST_IDLE` on the last step.

Top module: `vram_dma_seq`

## Requirements
- R1: A command write with bit 5 of `cmd_code` set looks at bits 7:6 of the high source byte. The values 00 and 01 start a bus transfer and 11 starts a copy. The value 10 only arms a fill, which starts on the next data-port write. A command write without bit 5 starts nothing and produces no write request.
- R2: After each step the low source byte increments. The mid byte increments only when the low byte wraps from FF to 00. The high byte never changes. `bus_src` shows {high, mid, low}.
- R3: After each step the destination advances by the auto-increment value, zero-extended to 16 bits.
- R4: The length decrements by one per step, and the transfer ends on the step that brings it to zero. A length of zero at start gives 65536 steps.
- R5: A bus step is made only in a valid slot that is not a refresh slot and whose preceding valid slot was not a refresh slot. A fill step is also blocked in a refresh slot.
- R6: A bus step issues a word write to the destination itself. Its data is `bus_rdata`, its code is `cmd_code[4:0]`, `wr_lane8`=0, and `wr_delay` is FIFO_LAT×16 when `wide_mode`=1 or FIFO_LAT×20 when it is 0.
- R7: A copy step reads the byte at {mid, low} XOR 1 through `mem_raddr`/`mem_rdata`. It issues a byte write of that byte, zero-extended in `wr_data`, to destination XOR 1, with code 5'h01, `wr_lane8`=1 and delay 0. A copy step happens only in a slot with `slot_unused`=1 and `wr_pending`=0.
- R8: A fill step issues a byte write of the fill value's high byte, zero-extended in `wr_data`, to destination XOR 1. It carries the command's code, `wr_lane8`=1 and delay 0, and happens only when `wr_pending`=0.
- R9: `busy` is high in the three running states and low after reset and while a fill is armed. While it is high, configuration writes are ignored. The `cfg_sel` encoding is 0 low source, 1 mid source, 2 high source, 3 length low, 4 length high, 5 auto-increment.
- R10: `done` pulses together with the write request of the final step, and `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration byte |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 6 | Command code; bit 5 requests a transfer |
| cmd_addr | input | 16 | Destination address loaded by the command |
| data_we | input | 1 | Data-port write strobe |
| data_wdata | input | 16 | Data-port word, the fill value |
| wide_mode | input | 1 | 1 for the wide display mode |
| slot_valid | input | 1 | An access slot occurs this cycle |
| slot_refresh | input | 1 | The current slot is a refresh slot |
| slot_unused | input | 1 | The current slot is free for a copy |
| wr_pending | input | 1 | Another write is still queued |
| bus_src | output | 24 | Current source address |
| bus_rdata | input | 16 | Word read from the external bus at `bus_src` |
| mem_raddr | output | 16 | Video memory read address for a copy |
| mem_rdata | input | 8 | Byte read from video memory |
| wr_valid | output | 1 | Write request this cycle |
| wr_addr | output | 16 | Write address |
| wr_data | output | 16 | Write data |
| wr_code | output | 5 | Target code |
| wr_lane8 | output | 1 | 1 for a single-byte write |
| wr_delay | output | DLY_W | Queue latency in clocks |
| busy | output | 1 | Transfer running |
| done | output | 1 | Final step pulse |

## Verification
Bus transfers are run in both display modes, with a refresh slot placed between steps. This separates correct refresh gating from gating that checks only the current slot, and shows the two latency values apart. Starting the low source byte at FE exposes the mid-byte carry. Configuration writes made mid-transfer show whether the lock holds. Fill and copy are run with pending writes and unused-slot flags toggled, so that a step issued too early is caught. A zero-length fill shows the 65536-step count, and a command without the start bit shows that nothing starts.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_ARM,
        ST_BUS,
        ST_FILL,
        ST_COPY
    } dma_state_e;

    localparam logic [2:0] SEL_SRC_LO  = 3'd0;
    localparam logic [2:0] SEL_SRC_MID = 3'd1;
    localparam logic [2:0] SEL_SRC_HI  = 3'd2;
    localparam logic [2:0] SEL_LEN_LO  = 3'd3;
    localparam logic [2:0] SEL_LEN_HI  = 3'd4;
    localparam logic [2:0] SEL_INC     = 3'd5;

    localparam logic [1:0] MODE_FILL = 2'b10;
    localparam logic [1:0] MODE_COPY = 2'b11;

    localparam int         START_BIT    = 5;
    localparam logic [4:0] CODE_VRAM_WR = 5'h01;

endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
    import vdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [7:0]  cfg_wdata,
    input  logic        cfg_lock,
    input  logic        dst_load,
    input  logic [15:0] dst_in,
    input  logic        step,
    output logic [7:0]  src_lo,
    output logic [7:0]  src_mid,
    output logic [7:0]  src_hi,
    output logic [15:0] dst,
    output logic        last_step
);

    logic [15:0] len_q;
    logic [7:0]  inc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_lo  <= '0;
            src_mid <= '0;
            src_hi  <= '0;
            len_q   <= '0;
            inc_q   <= '0;
            dst     <= '0;
        end else begin
            if (cfg_we && !cfg_lock) begin
                unique case (cfg_sel)
                    SEL_SRC_LO:  src_lo       <= cfg_wdata;
                    SEL_SRC_MID: src_mid      <= cfg_wdata;
                    SEL_SRC_HI:  src_hi       <= cfg_wdata;
                    SEL_LEN_LO:  len_q[7:0]   <= cfg_wdata;
                    SEL_LEN_HI:  len_q[15:8]  <= cfg_wdata;
                    SEL_INC:     inc_q        <= cfg_wdata;
                    default: ;
                endcase
            end
            if (dst_load) begin
                dst <= dst_in;
            end
            if (step) begin
                src_lo <= src_lo + 8'd1;
                if (src_lo == 8'hFF) begin
                    src_mid <= src_mid + 8'd1;
                end
                dst   <= dst + {8'h00, inc_q};
                len_q <= len_q - 16'd1;
            end
        end
    end

    assign last_step = (len_q == 16'd1);

endmodule

// File: rtl/vdma_slot_gate.sv
module vdma_slot_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_valid,
    input  logic slot_refresh,
    input  logic slot_unused,
    input  logic wr_pending,
    output logic bus_ok,
    output logic fill_ok,
    output logic copy_ok
);

    logic prev_ref_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ref_q <= 1'b0;
        end else if (slot_valid) begin
            prev_ref_q <= slot_refresh;
        end
    end

    assign bus_ok  = slot_valid && !slot_refresh && !prev_ref_q;
    assign fill_ok = slot_valid && !slot_refresh && !wr_pending;
    assign copy_ok = slot_valid && slot_unused && !wr_pending;

endmodule

// File: rtl/vdma_wr_fmt.sv
module vdma_wr_fmt
    import vdma_pkg::*;
#(
    parameter int FIFO_LAT = 4,
    parameter int DLY_W    = 7
) (
    input  dma_state_e         state,
    input  logic               step,
    input  logic               wide_mode,
    input  logic [15:0]        dst,
    input  logic [15:0]        bus_rdata,
    input  logic [7:0]         mem_rdata,
    input  logic [7:0]         fill_hi,
    input  logic [4:0]         code_q,
    output logic               wr_valid,
    output logic [15:0]        wr_addr,
    output logic [15:0]        wr_data,
    output logic [4:0]         wr_code,
    output logic               wr_lane8,
    output logic [DLY_W-1:0]   wr_delay
);

    localparam int DLY_WIDE   = FIFO_LAT * 16;
    localparam int DLY_NARROW = FIFO_LAT * 20;

    always_comb begin
        wr_valid = step;
        wr_addr  = dst ^ 16'h0001;
        wr_data  = '0;
        wr_code  = code_q;
        wr_lane8 = 1'b1;
        wr_delay = '0;
        unique case (state)
            ST_BUS: begin
                wr_addr  = dst;
                wr_data  = bus_rdata;
                wr_lane8 = 1'b0;
                wr_delay = wide_mode ? DLY_W'(DLY_WIDE) : DLY_W'(DLY_NARROW);
            end
            ST_FILL: begin
                wr_data = {8'h00, fill_hi};
            end
            ST_COPY: begin
                wr_data = {8'h00, mem_rdata};
                wr_code = CODE_VRAM_WR;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vram_dma_seq.sv
module vram_dma_seq
    import vdma_pkg::*;
#(
    parameter int FIFO_LAT = 4,
    parameter int DLY_W    = $clog2(FIFO_LAT * 20 + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [7:0]         cfg_wdata,
    input  logic               cmd_we,
    input  logic [5:0]         cmd_code,
    input  logic [15:0]        cmd_addr,
    input  logic               data_we,
    input  logic [15:0]        data_wdata,
    input  logic               wide_mode,
    input  logic               slot_valid,
    input  logic               slot_refresh,
    input  logic               slot_unused,
    input  logic               wr_pending,
    output logic [23:0]        bus_src,
    input  logic [15:0]        bus_rdata,
    output logic [15:0]        mem_raddr,
    input  logic [7:0]         mem_rdata,
    output logic               wr_valid,
    output logic [15:0]        wr_addr,
    output logic [15:0]        wr_data,
    output logic [4:0]         wr_code,
    output logic               wr_lane8,
    output logic [DLY_W-1:0]   wr_delay,
    output logic               busy,
    output logic               done
);

    dma_state_e  state_q, state_d;
    logic [7:0]  src_lo, src_mid, src_hi;
    logic [15:0] dst;
    logic        last_step;
    logic        bus_ok, fill_ok, copy_ok;
    logic        step;
    logic        accept_cmd;
    logic [4:0]  code_q;
    logic [7:0]  fill_hi_q;

    assign accept_cmd = cmd_we && !busy;

    vdma_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_lock  (busy),
        .dst_load  (accept_cmd),
        .dst_in    (cmd_addr),
        .step      (step),
        .src_lo    (src_lo),
        .src_mid   (src_mid),
        .src_hi    (src_hi),
        .dst       (dst),
        .last_step (last_step)
    );

    vdma_slot_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_valid   (slot_valid),
        .slot_refresh (slot_refresh),
        .slot_unused  (slot_unused),
        .wr_pending   (wr_pending),
        .bus_ok       (bus_ok),
        .fill_ok      (fill_ok),
        .copy_ok      (copy_ok)
    );

    vdma_wr_fmt #(
        .FIFO_LAT (FIFO_LAT),
        .DLY_W    (DLY_W)
    ) u_fmt (
        .state     (state_q),
        .step      (step),
        .wide_mode (wide_mode),
        .dst       (dst),
        .bus_rdata (bus_rdata),
        .mem_rdata (mem_rdata),
        .fill_hi   (fill_hi_q),
        .code_q    (code_q),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_code   (wr_code),
        .wr_lane8  (wr_lane8),
        .wr_delay  (wr_delay)
    );

    // State register and command-side captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            code_q    <= '0;
            fill_hi_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept_cmd) begin
                code_q <= cmd_code[4:0];
            end
            if (state_q == ST_FILL_ARM && data_we && !cmd_we) begin
                fill_hi_q <= data_wdata[15:8];
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FILL_ARM: begin
                if (cmd_we) begin
                    if (cmd_code[START_BIT]) begin
                        unique case (src_hi[7:6])
                            MODE_FILL: state_d = ST_FILL_ARM;
                            MODE_COPY: state_d = ST_COPY;
                            default:   state_d = ST_BUS;
                        endcase
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (state_q == ST_FILL_ARM && data_we) begin
                    state_d = ST_FILL;
                end
            end
            ST_BUS, ST_FILL, ST_COPY: begin
                if (step && last_step) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs derived from the current state
    always_comb begin
        busy = 1'b0;
        step = 1'b0;
        unique case (state_q)
            ST_BUS: begin
                busy = 1'b1;
                step = bus_ok;
            end
            ST_FILL: begin
                busy = 1'b1;
                step = fill_ok;
            end
            ST_COPY: begin
                busy = 1'b1;
                step = copy_ok;
            end
            default: ;
        endcase
        done      = step && last_step;
        bus_src   = {src_hi, src_mid, src_lo};
        mem_raddr = {src_mid, src_lo} ^ 16'h0001;
    end

endmodule

// File: rtl/vdma_checker.sv
module vdma_checker #(
    parameter int DLY_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slot_valid,
    input logic             slot_refresh,
    input logic             slot_unused,
    input logic             wr_pending,
    input logic [23:0]      bus_src,
    input logic             wr_valid,
    input logic             wr_lane8,
    input logic [DLY_W-1:0] wr_delay,
    input logic             busy,
    input logic             done
);

    logic last_ref_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ref_q <= 1'b0;
        end else if (slot_valid) begin
            last_ref_q <= slot_refresh;
        end
    end

    assert_bus_refresh_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_lane8) |-> (!slot_refresh && !last_ref_q));

    assert_byte_no_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_lane8) |-> !wr_pending);

    assert_copy_or_fill_no_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_lane8) |-> (wr_delay == '0));

    assert_write_in_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (busy && slot_valid));

    assert_low_src_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (bus_src[7:0] == $past(bus_src[7:0]) + 8'd1));

    assert_high_src_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (bus_src[23:16] == $past(bus_src[23:16])));

    assert_done_with_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> wr_valid);

    assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // slot_unused is observed only to keep the checker port set aligned with the slot inputs
    assert_unused_known_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_lane8 && slot_unused) |-> slot_valid);

endmodule

bind vram_dma_seq vdma_checker #(.DLY_W(DLY_W)) u_vdma_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_valid   (slot_valid),
    .slot_refresh (slot_refresh),
    .slot_unused  (slot_unused),
    .wr_pending   (wr_pending),
    .bus_src      (bus_src),
    .wr_valid     (wr_valid),
    .wr_lane8     (wr_lane8),
    .wr_delay     (wr_delay),
    .busy         (busy),
    .done         (done)
);

// File: tb/test_vram_dma_seq.sv
`timescale 1ns/1ps
module test_vram_dma_seq;

    localparam int FIFO_LAT = 4;
    localparam int DLY_W    = $clog2(FIFO_LAT * 20 + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_sel = '0;
    logic [7:0]        cfg_wdata = '0;
    logic              cmd_we = 1'b0;
    logic [5:0]        cmd_code = '0;
    logic [15:0]       cmd_addr = '0;
    logic              data_we = 1'b0;
    logic [15:0]       data_wdata = '0;
    logic              wide_mode = 1'b1;
    logic              slot_valid = 1'b0;
    logic              slot_refresh = 1'b0;
    logic              slot_unused = 1'b0;
    logic              wr_pending = 1'b0;
    logic [23:0]       bus_src;
    logic [15:0]       bus_rdata;
    logic [15:0]       mem_raddr;
    logic [7:0]        mem_rdata;
    logic              wr_valid;
    logic [15:0]       wr_addr;
    logic [15:0]       wr_data;
    logic [4:0]        wr_code;
    logic              wr_lane8;
    logic [DLY_W-1:0]  wr_delay;
    logic              busy;
    logic              done;

    always #2 clk = ~clk;

    // Stubs for the external bus and the video memory
    assign bus_rdata = bus_src[15:0] ^ 16'hA5C3;
    assign mem_rdata = mem_raddr[7:0] ^ mem_raddr[15:8] ^ 8'h3C;

    vram_dma_seq #(.FIFO_LAT(FIFO_LAT)) i_vram_dma_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cmd_we(cmd_we), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .data_we(data_we), .data_wdata(data_wdata), .wide_mode(wide_mode),
        .slot_valid(slot_valid), .slot_refresh(slot_refresh), .slot_unused(slot_unused),
        .wr_pending(wr_pending), .bus_src(bus_src), .bus_rdata(bus_rdata),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_code(wr_code), .wr_lane8(wr_lane8),
        .wr_delay(wr_delay), .busy(busy), .done(done)
    );

    typedef struct {
        logic [15:0] a;
        logic [15:0] d;
        logic [4:0]  c;
        logic        l;
        logic [6:0]  y;
        logic        dn;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;

    // Reference model state
    logic [7:0]  m_lo = 0, m_mid = 0, m_hi = 0, m_inc = 0;
    logic [15:0] m_len = 0, m_dst = 0, m_fill = 0;
    logic [4:0]  m_code = 0;
    bit          m_busy = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cfg_we = 0; cmd_we = 0; data_we = 0;
        slot_valid = 0; slot_refresh = 0; slot_unused = 0; wr_pending = 0;
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [7:0] v);
        tick();
        cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
        if (!m_busy) begin
            case (sel)
                3'd0: m_lo = v;
                3'd1: m_mid = v;
                3'd2: m_hi = v;
                3'd3: m_len[7:0] = v;
                3'd4: m_len[15:8] = v;
                3'd5: m_inc = v;
                default: ;
            endcase
        end
    endtask

    task automatic cmd(input logic [5:0] code, input logic [15:0] addr);
        tick();
        cmd_we = 1; cmd_code = code; cmd_addr = addr;
        m_code = code[4:0];
        m_dst  = addr;
        if (code[5] && m_hi[7:6] != 2'b10) m_busy = 1;
    endtask

    task automatic dwrite(input logic [15:0] v);
        tick();
        data_we = 1; data_wdata = v;
        m_fill = v;
        m_busy = 1;
    endtask

    // Driver: pushes what the requirements predict for one step
    task automatic exp_step(input int kind);
        exp_t e;
        logic [15:0] ra;
        e.dn = 0;
        if (kind == 0) begin
            e.a = m_dst; e.d = {m_mid, m_lo} ^ 16'hA5C3; e.c = m_code; e.l = 0;
            e.y = wide_mode ? 7'(FIFO_LAT * 16) : 7'(FIFO_LAT * 20); e.req = "R6";
        end else if (kind == 1) begin
            e.a = m_dst ^ 16'h1; e.d = {8'h00, m_fill[15:8]}; e.c = m_code; e.l = 1;
            e.y = 0; e.req = "R8";
        end else begin
            ra = {m_mid, m_lo} ^ 16'h1;
            e.a = m_dst ^ 16'h1; e.d = {8'h00, ra[7:0] ^ ra[15:8] ^ 8'h3C}; e.c = 5'h01;
            e.l = 1; e.y = 0; e.req = "R7";
        end
        m_lo = m_lo + 1;
        if (m_lo == 8'h00) m_mid = m_mid + 1;
        m_dst = m_dst + {8'h00, m_inc};
        m_len = m_len - 1;
        if (m_len == 16'h0) begin
            e.dn = 1;
            m_busy = 0;
        end
        exp_q.push_back(e);
    endtask

    task automatic slot(input bit rf, input bit un, input bit pd, input int kind);
        tick();
        slot_valid = 1; slot_refresh = rf; slot_unused = un; wr_pending = pd;
        if (kind >= 0) exp_step(kind);
    endtask

    // Monitor: compares each write request with the queue head
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R1 R5 R7 R8", "unexpected write addr", {16'h0, wr_addr}, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(wr_addr == e.a, e.req, "wr_addr (R3)", {16'h0, wr_addr}, {16'h0, e.a});
                chk(wr_data == e.d, e.req, "wr_data", {16'h0, wr_data}, {16'h0, e.d});
                chk(wr_code == e.c, e.req, "wr_code", {27'h0, wr_code}, {27'h0, e.c});
                chk(wr_lane8 == e.l, e.req, "wr_lane8", {31'h0, wr_lane8}, {31'h0, e.l});
                chk(wr_delay == e.y, e.req, "wr_delay", {25'h0, wr_delay}, {25'h0, e.y});
                chk(done == e.dn, "R4 R10", "done", {31'h0, done}, {31'h0, e.dn});
            end
        end
    end

    task automatic drained(input string req);
        @(negedge clk);
        chk(exp_q.size() == 0, req, "missing writes", exp_q.size(), 0);
    endtask

    initial begin
        #(200000 * 4);
        chk(0, "R4", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(busy == 0, "R9", "busy after reset", busy, 0);
        chk(wr_valid == 0, "R10", "wr_valid after reset", wr_valid, 0);
        chk(done == 0, "R10", "done after reset", done, 0);

        // Bus transfer, wide mode, refresh gap, mid carry, locked config
        cfg(0, 8'hFE); cfg(1, 8'h34); cfg(2, 8'h12);
        cfg(3, 8'h03); cfg(4, 8'h00); cfg(5, 8'h02);
        wide_mode = 1;
        cmd(6'h21, 16'h1000);
        tick();
        @(negedge clk);
        chk(busy == 1, "R1", "bus start busy", busy, 1);
        slot(0, 0, 0, 0);
        cfg(5, 8'h07);
        cfg(2, 8'hC0);
        slot(1, 0, 0, -1);
        slot(0, 0, 0, -1);
        slot(0, 0, 0, 0);
        slot(0, 0, 0, 0);
        tick();
        drained("R5");
        chk(busy == 0, "R10", "busy after bus done", busy, 0);
        chk(bus_src == 24'h123501, "R2", "source after carry", bus_src, 24'h123501);

        // Bus transfer with mode bits 01, narrow mode
        cfg(2, 8'h40); cfg(3, 8'h01); cfg(4, 8'h00);
        wide_mode = 0;
        cmd(6'h23, 16'h0100);
        slot(0, 0, 0, 0);
        tick();
        drained("R6");
        chk(bus_src[23:16] == 8'h40, "R9", "high src after unlocked write", bus_src[23:16], 8'h40);
        wide_mode = 1;

        // Command without the start bit
        cmd(6'h01, 16'h0200);
        tick();
        @(negedge clk);
        chk(busy == 0, "R1", "no start without bit 5", busy, 0);
        slot(0, 0, 0, -1);
        tick();

        // Fill: armed until data write, pending blocks
        cfg(2, 8'h80); cfg(3, 8'h02); cfg(5, 8'h01);
        cmd(6'h21, 16'h2000);
        tick();
        @(negedge clk);
        chk(busy == 0, "R1", "fill armed busy", busy, 0);
        slot(0, 0, 0, -1);
        dwrite(16'hAB12);
        tick();
        @(negedge clk);
        chk(busy == 1, "R1", "fill started busy", busy, 1);
        slot(0, 0, 1, -1);
        slot(0, 0, 0, 1);
        slot(0, 0, 0, 1);
        tick();
        drained("R8");

        // Copy: needs unused slot and no pending write
        cfg(0, 8'h10); cfg(1, 8'h05); cfg(2, 8'hC0); cfg(3, 8'h02);
        cmd(6'h25, 16'h3000);
        slot(0, 0, 0, -1);
        slot(0, 1, 1, -1);
        slot(0, 1, 0, 2);
        slot(0, 1, 0, 2);
        tick();
        drained("R7");
        chk(busy == 0, "R10", "busy after copy", busy, 0);

        // Zero length fill gives 65536 steps
        cfg(2, 8'h80); cfg(3, 8'h00); cfg(4, 8'h00);
        cmd(6'h21, 16'h0000);
        dwrite(16'h5500);
        for (int i = 0; i < 65535; i++) slot(0, 0, 0, 1);
        tick();
        @(negedge clk);
        chk(busy == 1, "R4", "busy before step 65536", busy, 1);
        slot(0, 0, 0, 1);
        tick();
        drained("R4");
        chk(busy == 0, "R4", "busy after 65536 steps", busy, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule